// File: doc/BRIEF.md
# Per-Channel Block Statistics Engine

This block keeps block-based performance statistics for up to 127 monitored channels of a cell-switched data path. A programmable lookup table ties each channel slot to a 16-bit connection identifier and a block length of 128, 256, 512 or 1024 cells. Every qualified cell event carries an identifier, an 8-bit block error result and a signed 16-bit user cell difference. When the identifier hits a table entry, the engine advances that slot's cell-in-block count. When the block completes, the engine updates the slot's block, error, lost, misinserted, severely-errored-block and total-cell counters.

A severely errored block is decided against three programmable dividers, one each for errored, lost and misinserted cells. Each threshold is the slot's own block length shifted right by its divider. A CPU-side request snapshots one slot and clears it. A separate request clears the cell-in-block count. A counter rollover latches a status word and drives a fixed-length, active-low, maskable interrupt pulse. The pulse is produced by a two-state machine. In IRQ_IDLE a rollover with the interrupt enabled moves it to IRQ_HOLD. In IRQ_HOLD it counts down the pulse length and then returns to IRQ_IDLE.

Top module: `blkstat_engine`

## Requirements
- R1: Slots 1 to 127 each hold an identifier and a size code. An identifier of 0xFFFF marks a slot inactive and is never matched. Events whose identifier matches no active slot change nothing. When two slots hold the same identifier, only the lowest-numbered one counts.
- R2: The block length is 128 shifted left by the size code (00=128, 01=256, 10=512, 11=1024). Each threshold is the block length shifted right by its 3-bit divider. A divider of 0 disables that category for the severely-errored-block decision only.
- R3: When a matched event brings the cell-in-block count up to the block length, the block is complete. The blocks counter (24 bits) adds 1, the cell-in-block count returns to 0, and the total counter (32 bits) adds the block length. The total counter never changes at any other time.
- R4: Each matched event that does not complete a block increments the slot's 12-bit cell-in-block count.
- R5: At block completion the block error result is added to the errored counter. A positive cell difference is added to the lost counter. The magnitude of a negative cell difference is added to the misinserted counter. All three counters are 16 bits.
- R6: At block completion the 16-bit severely-errored-block counter adds 1 if any enabled category's amount is greater than or equal to its threshold.
- R7: A read request on a channel raises rd_valid one cycle later with that slot's values from before the request edge. It clears the blocks, severely-errored, errored, lost, misinserted and total counters. It leaves the cell-in-block count as it was. A cell-in-block clear request also produces a snapshot.
- R8: The cell-in-block count is cleared only by its own clear request, or by block completion.
- R9: When a clear and a matched event hit the same slot in the same cycle, the cleared counters end at zero.
- R10: A rollover latches the status word. Bits 6:0 are one-hot: 0 blocks, 1 cell-in-block, 2 severely errored, 3 errored, 4 lost, 5 misinserted, 6 total, with the lowest set bit winning. Bits 13:7 hold the slot. A latched word holds until a status read clears it; a rollover in the same cycle as the read is latched.
- R11: A rollover with irq_en high drives irq_n low for exactly 4 cycles, starting after the rollover edge. With irq_en low, the status word is still latched but no pulse is produced. A rollover during a pulse does not extend it.
- R12: Every counter wraps modulo 2 to the power of its width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_slot | input | 7 | Slot written (1..127) |
| tbl_id | input | 16 | Identifier for the slot, 0xFFFF = inactive |
| tbl_bsz | input | 2 | Block size code |
| thr_we | input | 1 | Threshold divider write strobe |
| thr_err_div | input | 3 | Errored-cell divider |
| thr_lost_div | input | 3 | Lost-cell divider |
| thr_mis_div | input | 3 | Misinserted-cell divider |
| irq_en | input | 1 | Interrupt enable (1 = not masked) |
| ev_valid | input | 1 | Qualified cell event |
| ev_id | input | 16 | Event connection identifier |
| ev_bler | input | 8 | Block error result |
| ev_tucd | input | 16 | Signed user cell difference |
| rd_req | input | 1 | Read-and-clear request |
| clr_cib_req | input | 1 | Cell-in-block clear request |
| rd_ch | input | 7 | Slot for either request |
| st_rd | input | 1 | Status read, clears the status word |
| rd_valid | output | 1 | Snapshot valid |
| rd_blocks | output | 24 | Blocks snapshot |
| rd_cib | output | 12 | Cell-in-block snapshot |
| rd_ses | output | 16 | Severely errored blocks snapshot |
| rd_err | output | 16 | Errored cells snapshot |
| rd_lost | output | 16 | Lost cells snapshot |
| rd_mis | output | 16 | Misinserted cells snapshot |
| rd_total | output | 32 | Total cells snapshot |
| st_word | output | 14 | Latched status word |
| irq_n | output | 1 | Active-low interrupt pulse |

## Verification
The checks assume that a slot's size code is not rewritten while its cell-in-block count is nonzero. They also assume that read and clear requests name slot 1 to 127. Under those conditions the cell-in-block snapshot stays below the largest block length, and the status channel field is nonzero whenever a flag is set. The stimulus writes the table once at the start and never changes it afterwards. It only ever issues requests for configured slots. It drives the rollover cases through large cell differences on active slots, so that every pulse starts from IRQ_IDLE.

// File: rtl/blkstat_pkg.sv
package blkstat_pkg;
    localparam int ID_W   = 16;
    localparam int BSZ_W  = 2;
    localparam int DIV_W  = 3;
    localparam int BLK_W  = 24;
    localparam int CIB_W  = 12;
    localparam int CNT_W  = 16;
    localparam int TOT_W  = 32;
    localparam int FLG_W  = 7;
    localparam int LEN_W  = 11;
    localparam int AMT_W  = CNT_W + 1;

    localparam int F_BLK  = 0;
    localparam int F_CIB  = 1;
    localparam int F_SES  = 2;
    localparam int F_ERR  = 3;
    localparam int F_LOST = 4;
    localparam int F_MIS  = 5;
    localparam int F_TOT  = 6;

    function automatic logic [LEN_W-1:0] blk_len(input logic [BSZ_W-1:0] code);
        return LEN_W'(128) << code;
    endfunction

    function automatic logic thr_met(input logic [LEN_W-1:0] len,
                                     input logic [DIV_W-1:0] dv,
                                     input logic [AMT_W-1:0] amt);
        logic [LEN_W-1:0] lim;
        lim = len >> dv;
        return (dv != '0) && (amt >= AMT_W'(lim));
    endfunction
endpackage

// File: rtl/blkstat_cam.sv
module blkstat_cam
    import blkstat_pkg::*;
#(
    parameter int N_SLOTS = 127,
    localparam int SLOT_W = $clog2(N_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [BSZ_W-1:0]  wr_bsz,
    input  logic [ID_W-1:0]   lk_id,
    output logic              hit,
    output logic [SLOT_W-1:0] hit_slot,
    output logic [BSZ_W-1:0]  hit_bsz
);
    logic [ID_W-1:0]  id_q  [0:N_SLOTS];
    logic [BSZ_W-1:0] bsz_q [0:N_SLOTS];
    logic [N_SLOTS:1] match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= N_SLOTS; i++) begin
                id_q[i]  <= '1;
                bsz_q[i] <= '0;
            end
        end else if (wr_en && wr_slot != '0) begin
            id_q[wr_slot]  <= wr_id;
            bsz_q[wr_slot] <= wr_bsz;
        end
    end

    for (genvar g = 1; g <= N_SLOTS; g++) begin : g_cmp
        assign match[g] = (id_q[g] == lk_id) && (lk_id != '1);
    end

    always_comb begin
        hit      = 1'b0;
        hit_slot = '0;
        for (int i = N_SLOTS; i >= 1; i--) begin
            if (match[i]) begin
                hit      = 1'b1;
                hit_slot = SLOT_W'(i);
            end
        end
    end

    assign hit_bsz = bsz_q[hit_slot];
endmodule

// File: rtl/blkstat_calc.sv
module blkstat_calc
    import blkstat_pkg::*;
(
    input  logic [BSZ_W-1:0] bsz,
    input  logic [DIV_W-1:0] dv_err,
    input  logic [DIV_W-1:0] dv_lost,
    input  logic [DIV_W-1:0] dv_mis,
    input  logic [7:0]       bler,
    input  logic [15:0]      tucd,
    input  logic [CIB_W-1:0] cur_cib,
    input  logic [BLK_W-1:0] cur_blk,
    input  logic [CNT_W-1:0] cur_ses,
    input  logic [CNT_W-1:0] cur_err,
    input  logic [CNT_W-1:0] cur_lost,
    input  logic [CNT_W-1:0] cur_mis,
    input  logic [TOT_W-1:0] cur_tot,
    output logic [CIB_W-1:0] nxt_cib,
    output logic [BLK_W-1:0] nxt_blk,
    output logic [CNT_W-1:0] nxt_ses,
    output logic [CNT_W-1:0] nxt_err,
    output logic [CNT_W-1:0] nxt_lost,
    output logic [CNT_W-1:0] nxt_mis,
    output logic [TOT_W-1:0] nxt_tot,
    output logic [FLG_W-1:0] ovf
);
    logic [LEN_W-1:0] len;
    logic [CIB_W:0]   s_cib;
    logic             done, sev;
    logic [AMT_W-1:0] a_err, a_lost, a_mis;
    logic [BLK_W:0]   s_blk;
    logic [CNT_W:0]   s_ses, s_err, s_lost, s_mis;
    logic [TOT_W:0]   s_tot;

    always_comb begin
        len    = blk_len(bsz);
        s_cib  = {1'b0, cur_cib} + (CIB_W+1)'(1);
        done   = (s_cib[CIB_W-1:0] == CIB_W'(len));
        a_err  = AMT_W'(bler);
        a_lost = tucd[15] ? '0 : {1'b0, tucd};
        a_mis  = tucd[15] ? (AMT_W'(0) - {1'b1, tucd}) : '0;
        sev    = thr_met(len, dv_err, a_err) | thr_met(len, dv_lost, a_lost)
               | thr_met(len, dv_mis, a_mis);
        s_blk  = {1'b0, cur_blk}  + (BLK_W+1)'(1);
        s_ses  = {1'b0, cur_ses}  + (CNT_W+1)'(sev);
        s_err  = {1'b0, cur_err}  + a_err;
        s_lost = {1'b0, cur_lost} + a_lost;
        s_mis  = {1'b0, cur_mis}  + a_mis;
        s_tot  = {1'b0, cur_tot}  + (TOT_W+1)'(len);

        nxt_cib  = done ? '0 : s_cib[CIB_W-1:0];
        nxt_blk  = done ? s_blk[BLK_W-1:0]  : cur_blk;
        nxt_ses  = done ? s_ses[CNT_W-1:0]  : cur_ses;
        nxt_err  = done ? s_err[CNT_W-1:0]  : cur_err;
        nxt_lost = done ? s_lost[CNT_W-1:0] : cur_lost;
        nxt_mis  = done ? s_mis[CNT_W-1:0]  : cur_mis;
        nxt_tot  = done ? s_tot[TOT_W-1:0]  : cur_tot;

        ovf         = '0;
        ovf[F_BLK]  = done & s_blk[BLK_W];
        ovf[F_CIB]  = !done & s_cib[CIB_W];
        ovf[F_SES]  = done & s_ses[CNT_W];
        ovf[F_ERR]  = done & s_err[CNT_W];
        ovf[F_LOST] = done & s_lost[CNT_W];
        ovf[F_MIS]  = done & s_mis[CNT_W];
        ovf[F_TOT]  = done & s_tot[TOT_W];
    end
endmodule

// File: rtl/blkstat_irq.sv
module blkstat_irq #(
    parameter int PULSE_CYC = 4,
    localparam int CW = $clog2(PULSE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic irq_n
);
    typedef enum logic {IRQ_IDLE, IRQ_HOLD} irq_state_e;

    irq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            IRQ_IDLE: if (trig) begin
                state_d = IRQ_HOLD;
                cnt_d   = CW'(PULSE_CYC - 1);
            end
            IRQ_HOLD: if (cnt_q == '0) state_d = IRQ_IDLE;
                      else             cnt_d   = cnt_q - CW'(1);
            default:  state_d = IRQ_IDLE;
        endcase
    end

    always_comb irq_n = (state_q != IRQ_HOLD);
endmodule

// File: rtl/blkstat_engine.sv
module blkstat_engine
    import blkstat_pkg::*;
#(
    parameter int N_SLOTS   = 127,
    parameter int PULSE_CYC = 4,
    localparam int SLOT_W   = $clog2(N_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [SLOT_W-1:0] tbl_slot,
    input  logic [ID_W-1:0]   tbl_id,
    input  logic [BSZ_W-1:0]  tbl_bsz,
    input  logic              thr_we,
    input  logic [DIV_W-1:0]  thr_err_div,
    input  logic [DIV_W-1:0]  thr_lost_div,
    input  logic [DIV_W-1:0]  thr_mis_div,
    input  logic              irq_en,
    input  logic              ev_valid,
    input  logic [ID_W-1:0]   ev_id,
    input  logic [7:0]        ev_bler,
    input  logic [15:0]       ev_tucd,
    input  logic              rd_req,
    input  logic              clr_cib_req,
    input  logic [SLOT_W-1:0] rd_ch,
    input  logic              st_rd,
    output logic              rd_valid,
    output logic [BLK_W-1:0]  rd_blocks,
    output logic [CIB_W-1:0]  rd_cib,
    output logic [CNT_W-1:0]  rd_ses,
    output logic [CNT_W-1:0]  rd_err,
    output logic [CNT_W-1:0]  rd_lost,
    output logic [CNT_W-1:0]  rd_mis,
    output logic [TOT_W-1:0]  rd_total,
    output logic [SLOT_W+FLG_W-1:0] st_word,
    output logic              irq_n
);
    logic [BLK_W-1:0] q_blk  [0:N_SLOTS];
    logic [CIB_W-1:0] q_cib  [0:N_SLOTS];
    logic [CNT_W-1:0] q_ses  [0:N_SLOTS];
    logic [CNT_W-1:0] q_err  [0:N_SLOTS];
    logic [CNT_W-1:0] q_lost [0:N_SLOTS];
    logic [CNT_W-1:0] q_mis  [0:N_SLOTS];
    logic [TOT_W-1:0] q_tot  [0:N_SLOTS];

    logic [DIV_W-1:0] dv_err_q, dv_lost_q, dv_mis_q;
    logic              hit, upd, ovf_any;
    logic [SLOT_W-1:0] hit_slot;
    logic [BSZ_W-1:0]  hit_bsz;
    logic [CIB_W-1:0]  n_cib;
    logic [BLK_W-1:0]  n_blk;
    logic [CNT_W-1:0]  n_ses, n_err, n_lost, n_mis;
    logic [TOT_W-1:0]  n_tot;
    logic [FLG_W-1:0]  ovf, ovf_hot;
    logic [SLOT_W+FLG_W-1:0] st_q;

    blkstat_cam #(.N_SLOTS(N_SLOTS)) u_cam (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_slot(tbl_slot),
        .wr_id(tbl_id), .wr_bsz(tbl_bsz), .lk_id(ev_id),
        .hit(hit), .hit_slot(hit_slot), .hit_bsz(hit_bsz)
    );

    blkstat_calc u_calc (
        .bsz(hit_bsz), .dv_err(dv_err_q), .dv_lost(dv_lost_q), .dv_mis(dv_mis_q),
        .bler(ev_bler), .tucd(ev_tucd),
        .cur_cib(q_cib[hit_slot]), .cur_blk(q_blk[hit_slot]), .cur_ses(q_ses[hit_slot]),
        .cur_err(q_err[hit_slot]), .cur_lost(q_lost[hit_slot]), .cur_mis(q_mis[hit_slot]),
        .cur_tot(q_tot[hit_slot]),
        .nxt_cib(n_cib), .nxt_blk(n_blk), .nxt_ses(n_ses), .nxt_err(n_err),
        .nxt_lost(n_lost), .nxt_mis(n_mis), .nxt_tot(n_tot), .ovf(ovf)
    );

    blkstat_irq #(.PULSE_CYC(PULSE_CYC)) u_irq (
        .clk(clk), .rst_n(rst_n), .trig(ovf_any && irq_en), .irq_n(irq_n)
    );

    always_comb begin
        upd     = ev_valid && hit;
        ovf_hot = upd ? (ovf & (~ovf + FLG_W'(1))) : '0;
        ovf_any = (ovf_hot != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= N_SLOTS; i++) begin
                q_blk[i] <= '0; q_cib[i] <= '0; q_ses[i] <= '0; q_err[i] <= '0;
                q_lost[i] <= '0; q_mis[i] <= '0; q_tot[i] <= '0;
            end
        end else begin
            if (upd) begin
                q_cib[hit_slot]  <= n_cib;
                q_blk[hit_slot]  <= n_blk;
                q_ses[hit_slot]  <= n_ses;
                q_err[hit_slot]  <= n_err;
                q_lost[hit_slot] <= n_lost;
                q_mis[hit_slot]  <= n_mis;
                q_tot[hit_slot]  <= n_tot;
            end
            if (rd_req) begin
                q_blk[rd_ch]  <= '0;
                q_ses[rd_ch]  <= '0;
                q_err[rd_ch]  <= '0;
                q_lost[rd_ch] <= '0;
                q_mis[rd_ch]  <= '0;
                q_tot[rd_ch]  <= '0;
            end
            if (clr_cib_req) q_cib[rd_ch] <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_blocks <= '0; rd_cib <= '0; rd_ses <= '0; rd_err <= '0;
            rd_lost <= '0; rd_mis <= '0; rd_total <= '0;
            dv_err_q <= '0; dv_lost_q <= '0; dv_mis_q <= '0;
            st_q <= '0;
        end else begin
            rd_valid <= rd_req || clr_cib_req;
            if (rd_req || clr_cib_req) begin
                rd_blocks <= q_blk[rd_ch];
                rd_cib    <= q_cib[rd_ch];
                rd_ses    <= q_ses[rd_ch];
                rd_err    <= q_err[rd_ch];
                rd_lost   <= q_lost[rd_ch];
                rd_mis    <= q_mis[rd_ch];
                rd_total  <= q_tot[rd_ch];
            end
            if (thr_we) begin
                dv_err_q  <= thr_err_div;
                dv_lost_q <= thr_lost_div;
                dv_mis_q  <= thr_mis_div;
            end
            if (st_rd)
                st_q <= ovf_any ? {hit_slot, ovf_hot} : '0;
            else if (st_q == '0 && ovf_any)
                st_q <= {hit_slot, ovf_hot};
        end
    end

    assign st_word = st_q;
endmodule

// File: rtl/blkstat_chk.sv
module blkstat_chk #(
    parameter int PULSE_CYC = 4,
    localparam int RW = $clog2(PULSE_CYC + 2)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        irq_en,
    input logic        irq_n,
    input logic        st_rd,
    input logic [13:0] st_word,
    input logic        rd_req,
    input logic        clr_cib_req,
    input logic        rd_valid,
    input logic [11:0] rd_cib
);
    logic [RW-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     low_run <= '0;
        else if (irq_n)                 low_run <= '0;
        else if (low_run != '1)         low_run <= low_run + RW'(1);
    end

    // R11: the low pulse lasts exactly PULSE_CYC cycles
    p_irq_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> (low_run == RW'(PULSE_CYC)));
    p_irq_max_r11: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= RW'(PULSE_CYC));
    // R11: a pulse starts only while enabled
    p_irq_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(irq_en));
    // R10: one flag at most, and a flag always carries a slot number
    p_st_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_word[6:0]));
    p_st_chan_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_word[6:0] != 7'd0) == (st_word[13:7] != 7'd0));
    // R10: a latched word holds until read
    p_st_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_word != 14'd0 && !st_rd) |=> $stable(st_word));
    // R7: snapshot strobe follows a request by one cycle
    p_rd_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || clr_cib_req) |=> rd_valid);
    p_rd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req || clr_cib_req) |=> !rd_valid);
    // R4: cell-in-block count stays below the largest block length
    p_cib_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_cib < 12'd1024));
endmodule

bind blkstat_engine blkstat_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .irq_n(irq_n), .st_rd(st_rd),
    .st_word(st_word), .rd_req(rd_req), .clr_cib_req(clr_cib_req),
    .rd_valid(rd_valid), .rd_cib(rd_cib)
);

// File: tb/blkstat_engine_tb.sv
module blkstat_engine_tb;
    logic clk = 0;
    logic rst_n = 0;
    logic tbl_we = 0; logic [6:0] tbl_slot = 0; logic [15:0] tbl_id = 0; logic [1:0] tbl_bsz = 0;
    logic thr_we = 0; logic [2:0] thr_err_div = 0, thr_lost_div = 0, thr_mis_div = 0;
    logic irq_en = 0, ev_valid = 0; logic [15:0] ev_id = 0; logic [7:0] ev_bler = 0;
    logic [15:0] ev_tucd = 0;
    logic rd_req = 0, clr_cib_req = 0, st_rd = 0; logic [6:0] rd_ch = 1;
    logic rd_valid; logic [23:0] rd_blocks; logic [11:0] rd_cib;
    logic [15:0] rd_ses, rd_err, rd_lost, rd_mis; logic [31:0] rd_total;
    logic [13:0] st_word; logic irq_n;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    blkstat_engine u_dut (.*);

    // behavioural reference state
    longint m_id[0:127], m_bs[0:127];
    longint m_blk[0:127], m_cib[0:127], m_ses[0:127], m_err[0:127];
    longint m_lost[0:127], m_mis[0:127], m_tot[0:127];
    longint m_de, m_dl, m_dm, m_st;
    int m_irq;
    bit e_rdv;
    longint e_blk, e_cib, e_ses, e_err, e_lost, e_mis, e_tot;

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic bump(inout longint v, input longint a, input int w, input int b, inout int fl);
        v = v + a;
        if (v >= (longint'(1) << w)) begin
            v = v - (longint'(1) << w);
            fl = fl | (1 << b);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 128; i++) begin
            m_id[i] = 16'hFFFF; m_bs[i] = 0; m_blk[i] = 0; m_cib[i] = 0; m_ses[i] = 0;
            m_err[i] = 0; m_lost[i] = 0; m_mis[i] = 0; m_tot[i] = 0;
        end
        m_de = 0; m_dl = 0; m_dm = 0; m_st = 0; m_irq = 0; e_rdv = 0;
    endtask

    task automatic model_step();
        int s, fl, pick;
        longint bs, c, t, la, ma;
        bit sev;
        s = 0; fl = 0;
        if (ev_valid && ev_id != 16'hFFFF)
            for (int i = 127; i >= 1; i--) if (m_id[i] == longint'(ev_id)) s = i;
        e_rdv = rd_req || clr_cib_req;
        if (e_rdv) begin
            e_blk = m_blk[rd_ch]; e_cib = m_cib[rd_ch]; e_ses = m_ses[rd_ch];
            e_err = m_err[rd_ch]; e_lost = m_lost[rd_ch]; e_mis = m_mis[rd_ch];
            e_tot = m_tot[rd_ch];
        end
        if (s != 0) begin
            bs = longint'(128) << m_bs[s];
            c = m_cib[s] + 1;
            if (c == bs) begin
                m_cib[s] = 0;
                t = longint'($signed(ev_tucd));
                la = (t > 0) ? t : 0;
                ma = (t < 0) ? -t : 0;
                sev = (m_de != 0 && longint'(ev_bler) >= (bs >> m_de)) ||
                      (m_dl != 0 && la >= (bs >> m_dl)) ||
                      (m_dm != 0 && ma >= (bs >> m_dm));
                bump(m_blk[s], 1, 24, 0, fl);
                bump(m_ses[s], sev ? 1 : 0, 16, 2, fl);
                bump(m_err[s], longint'(ev_bler), 16, 3, fl);
                bump(m_lost[s], la, 16, 4, fl);
                bump(m_mis[s], ma, 16, 5, fl);
                bump(m_tot[s], bs, 32, 6, fl);
            end else if (c == 4096) begin
                m_cib[s] = 0; fl = fl | 2;
            end else m_cib[s] = c;
        end
        pick = fl & (-fl);
        if (rd_req) begin
            m_blk[rd_ch] = 0; m_ses[rd_ch] = 0; m_err[rd_ch] = 0;
            m_lost[rd_ch] = 0; m_mis[rd_ch] = 0; m_tot[rd_ch] = 0;
        end
        if (clr_cib_req) m_cib[rd_ch] = 0;
        if (tbl_we && tbl_slot != 0) begin m_id[tbl_slot] = tbl_id; m_bs[tbl_slot] = tbl_bsz; end
        if (thr_we) begin m_de = thr_err_div; m_dl = thr_lost_div; m_dm = thr_mis_div; end
        if (st_rd) m_st = (pick != 0) ? ((longint'(s) << 7) | pick) : 0;
        else if (m_st == 0 && pick != 0) m_st = (longint'(s) << 7) | pick;
        if (m_irq > 0) m_irq--;
        else if (pick != 0 && irq_en) m_irq = 4;
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R11 irq_n", irq_n, (m_irq == 0) ? 1 : 0);
            chk("R10 st_word", st_word, m_st);
            chk("R7 rd_valid", rd_valid, e_rdv);
            if (e_rdv) begin
                chk("R3 rd_blocks", rd_blocks, e_blk);
                chk("R4 rd_cib", rd_cib, e_cib);
                chk("R6 rd_ses", rd_ses, e_ses);
                chk("R5 rd_err", rd_err, e_err);
                chk("R5 rd_lost", rd_lost, e_lost);
                chk("R5 rd_mis", rd_mis, e_mis);
                chk("R3 rd_total", rd_total, e_tot);
            end
        end
    end

    task automatic tick(); @(negedge clk); endtask

    task automatic wr_tbl(int slot, int id, int bsz);
        tbl_we = 1; tbl_slot = 7'(slot); tbl_id = 16'(id); tbl_bsz = 2'(bsz);
        tick(); tbl_we = 0;
    endtask

    task automatic events(int id, int bler, int tucd, int n);
        for (int i = 0; i < n; i++) begin
            ev_valid = 1; ev_id = 16'(id); ev_bler = 8'(bler); ev_tucd = 16'(tucd);
            tick();
        end
        ev_valid = 0;
    endtask

    task automatic do_read(int ch);
        rd_req = 1; rd_ch = 7'(ch); tick(); rd_req = 0;
    endtask

    task automatic do_clr(int ch);
        clr_cib_req = 1; rd_ch = 7'(ch); tick(); clr_cib_req = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        chk("R11 reset irq_n", irq_n, 1);
        chk("R10 reset st_word", st_word, 0);
        chk("R7 reset rd_valid", rd_valid, 0);
        rst_n = 1; tick();

        wr_tbl(1, 16'h0100, 0);
        wr_tbl(2, 16'h0200, 1);
        wr_tbl(3, 16'h0100, 0);
        wr_tbl(127, 16'h7FFF, 3);
        thr_we = 1; thr_err_div = 3; thr_lost_div = 0; thr_mis_div = 7; tick(); thr_we = 0;

        // R1, R4: partial block, foreign and null identifiers
        events(16'h0100, 0, 0, 127);
        events(16'h0300, 9, 9, 5);
        events(16'hFFFF, 9, 9, 5);
        do_read(1);
        chk("R4 cib after 127 cells", rd_cib, 127);
        chk("R3 no block yet", rd_blocks, 0);
        do_read(3);
        chk("R1 duplicate slot unused", rd_cib, 0);

        // R3, R5, R6, R2: block end; lost disabled, errored over threshold
        events(16'h0100, 20, 40, 1);
        do_read(1);
        chk("R3 blocks", rd_blocks, 1);
        chk("R3 total", rd_total, 128);
        chk("R7 cib kept after read", rd_cib, 0);
        chk("R5 err", rd_err, 20);
        chk("R5 lost", rd_lost, 40);
        chk("R6 ses", rd_ses, 1);

        // R2: just under threshold 128>>3 = 16
        events(16'h0100, 15, 0, 128);
        do_read(1);
        chk("R2 below threshold ses", rd_ses, 0);
        chk("R5 err 15", rd_err, 15);

        // R6: misinserted 1 meets 128>>7 = 1
        events(16'h0100, 0, -1, 128);
        do_read(1);
        chk("R5 mis", rd_mis, 1);
        chk("R6 ses on mis", rd_ses, 1);

        // R9: clear and block end on the same cycle
        events(16'h0200, 0, 0, 255);
        ev_valid = 1; ev_id = 16'h0200; ev_bler = 50; ev_tucd = 16'd300;
        rd_req = 1; rd_ch = 2; tick(); rd_req = 0; ev_valid = 0;
        do_read(2);
        chk("R9 blocks cleared", rd_blocks, 0);
        chk("R9 total cleared", rd_total, 0);
        events(16'h0200, 0, 0, 7);
        ev_valid = 1; ev_id = 16'h0200; clr_cib_req = 1; rd_ch = 2; tick();
        clr_cib_req = 0; ev_valid = 0;
        do_read(2);
        chk("R9 cib clear wins", rd_cib, 0);

        // R8: separate cell-in-block clear
        events(16'h0100, 0, 0, 10);
        do_clr(1);
        chk("R8 snapshot before clear", rd_cib, 10);
        do_read(1);
        chk("R8 cib cleared", rd_cib, 0);

        // R10, R11, R12: lost rollover on slot 127 with interrupts enabled
        irq_en = 1;
        events(16'h7FFF, 0, 32767, 3072);
        chk("R11 irq low", irq_n, 0);
        chk("R10 status word", st_word, 14'h3F90);
        repeat (6) tick();
        chk("R11 irq released", irq_n, 1);
        chk("R10 status held", st_word, 14'h3F90);
        st_rd = 1; tick(); st_rd = 0;
        chk("R10 status cleared", st_word, 0);
        do_read(127);
        chk("R12 lost wrapped", rd_lost, 32765);

        // R11 masked, R12 misinserted wrap on slot 1
        irq_en = 0;
        events(16'h0100, 0, -32768, 256);
        chk("R10 mis flag", st_word, 14'h00A0);
        repeat (5) begin
            chk("R11 masked", irq_n, 1);
            tick();
        end
        do_read(1);
        chk("R12 mis wrapped", rd_mis, 0);
        st_rd = 1; tick(); st_rd = 0;

        // mixed traffic checked cycle by cycle against the reference
        irq_en = 1;
        for (int k = 0; k < 3000; k++) begin
            int sel;
            sel = $urandom_range(0, 4);
            ev_valid = ($urandom_range(0, 9) < 7);
            ev_id = (sel == 0) ? 16'h0100 : (sel == 1) ? 16'h0200 : (sel == 2) ? 16'h7FFF :
                    (sel == 3) ? 16'h0300 : 16'hFFFF;
            ev_bler = 8'($urandom_range(0, 40));
            ev_tucd = 16'($signed($urandom_range(0, 40000)) - 20000);
            rd_req = ($urandom_range(0, 49) == 0);
            clr_cib_req = ($urandom_range(0, 99) == 0);
            rd_ch = ($urandom_range(0, 1) == 0) ? 7'd1 : 7'd2;
            st_rd = ($urandom_range(0, 39) == 0);
            thr_we = ($urandom_range(0, 199) == 0);
            thr_err_div = 3'($urandom_range(0, 7));
            thr_lost_div = 3'($urandom_range(0, 7));
            thr_mis_div = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 299) == 0) irq_en = ~irq_en;
            tick();
        end
        ev_valid = 0; rd_req = 0; clr_cib_req = 0; st_rd = 0; thr_we = 0;
        repeat (8) tick();
        finish_run();
    end
endmodule